// File: doc/BRIEF.md
# Slave Raster Start Aligner

This block brings a slave raster timing generator back up so that its vertical blank lines up with the vertical blank of a master generator, even when the two run from different pixel clocks and have different line lengths. It first works out a trigger point on the master raster, a line Y and a pixel X. Waiting from that point to the master's blank takes the same time as the slave needs to reach its own blank. It then stops the slave, holds it under the master's update lock with its enable set, and releases it the moment the master's live counters reach that point.

The timing arithmetic uses a fixed-point scale S (a parameter, default 10000). The scaled slave line time in master lines is L = S*slave_htotal*master_pclk/master_htotal/slave_pclk, with each division truncating. The whole-line part is XY = L/S. The trigger line is Y = master_vactive - XY - 1. The trigger pixel is X = ((XY+1)*S - L)*master_htotal/master_div/S. Every wait on the slave's status is a bounded poll. When a poll runs out, the block aborts to idle and flags a timeout.

Top module: `vblank_start_aligner`

## Requirements
- R1: After reset, slave_en, trig_armed, lock_master, release_pulse, busy, done and timeout_err are 0, and trig_x and trig_y are 0.
- R2: One cycle after a start is accepted, trig_y holds master_vactive - XY - 1, truncated to the port width. trig_x and trig_y then stay stable for as long as trig_armed is high.
- R3: trig_x holds ((XY+1)*S - L)*master_htotal/master_div/S. A master_div, master_htotal or slave_pclk of 0 is used as 1.
- R4: A start accepted in idle clears slave_en at once. slave_en stays 0 while the block is busy and not yet armed. The block arms only after a status poll that reads slave_running as 0.
- R5: slave_running is polled once on entry to a wait and then once every POLL_INTERVAL cycles. In the stop wait, if POLL_LIMIT polls all read 1, timeout_err rises 2+(POLL_LIMIT-1)*POLL_INTERVAL cycles after the start is accepted, and the block returns to idle with slave_en 0.
- R6: On arming, trig_armed, lock_master (slave under the master's update lock) and slave_en all go to 1 together, before any release.
- R7: release_pulse is high for exactly one cycle per alignment. It is high in the cycle after the clock edge at which master_hcount == trig_x and master_vcount == trig_y while armed.
- R8: When a run-wait poll reads slave_running as 1, the block disarms, clears trig_x and trig_y to 0, returns the slave to its own lock (lock_master 0), pulses done for one cycle and goes idle with slave_en still 1.
- R9: If POLL_LIMIT run-wait polls all read 0, the block sets timeout_err, disarms, clears trig_x and trig_y, drops lock_master and returns to idle.
- R10: start is ignored while busy is 1.
- R11: timeout_err stays set until the next accepted start, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request an alignment (accepted only while idle) |
| master_pclk | input | PCLK_W | Master pixel clock, 100 Hz units |
| slave_pclk | input | PCLK_W | Slave pixel clock, 100 Hz units |
| master_htotal | input | HT_W | Master line length in pixels |
| slave_htotal | input | HT_W | Slave line length in pixels |
| master_vactive | input | VT_W | Master active line count |
| master_div | input | DIV_W | Master pixel clock divider |
| master_hcount | input | HT_W | Live master horizontal counter |
| master_vcount | input | VT_W | Live master vertical counter |
| slave_running | input | 1 | Slave status: 1 running, 0 stopped |
| slave_en | output | 1 | Slave generator enable |
| trig_x | output | HT_W | Trigger pixel |
| trig_y | output | VT_W | Trigger line |
| trig_armed | output | 1 | Trigger point armed |
| lock_master | output | 1 | 1: slave under master's update lock; 0: its own lock |
| release_pulse | output | 1 | One-cycle slave release |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout_err | output | 1 | A status wait ran out of polls |

## Verification
The bench builds the block with POLL_INTERVAL = 4 and POLL_LIMIT = 6 and keeps the default widths and scale. This makes a full exhausted status wait last only 22 cycles, so both timeout paths and the exact poll spacing can be checked cycle by cycle. The master rasters are kept short (tens of pixels and lines), so the master counters reach each computed trigger point within a few thousand cycles. That keeps many random pixel-clock and line-length ratios within reach, along with the corner cases of a whole-line ratio and a zero divider.

// File: rtl/aligner_pkg.sv
package aligner_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CALC,
    S_STOP_WAIT,
    S_ARM,
    S_WAIT_MATCH,
    S_RUN_WAIT
  } align_state_t;

  function automatic logic [63:0] nz(input logic [63:0] v);
    return (v == 64'd0) ? 64'd1 : v;
  endfunction

  // scaled slave line time measured in master lines
  function automatic logic [63:0] scaled_lines(
    input logic [63:0] scale,
    input logic [63:0] m_pclk,
    input logic [63:0] s_pclk,
    input logic [63:0] m_ht,
    input logic [63:0] s_ht
  );
    return scale * s_ht * m_pclk / nz(m_ht) / nz(s_pclk);
  endfunction

  function automatic logic [63:0] trigger_line(
    input logic [63:0] scale,
    input logic [63:0] l,
    input logic [63:0] vact
  );
    return vact - (l / scale) - 64'd1;
  endfunction

  function automatic logic [63:0] trigger_pixel(
    input logic [63:0] scale,
    input logic [63:0] l,
    input logic [63:0] m_ht,
    input logic [63:0] div
  );
    logic [63:0] whole;
    whole = l / scale;
    return ((whole + 64'd1) * scale - l) * nz(m_ht) / nz(div) / scale;
  endfunction

endpackage

// File: rtl/aligner_calc.sv
module aligner_calc
  import aligner_pkg::*;
#(
  parameter int PCLK_W = 32,
  parameter int HT_W   = 15,
  parameter int VT_W   = 15,
  parameter int DIV_W  = 8,
  parameter int SCALE  = 10000
) (
  input  logic [PCLK_W-1:0] master_pclk,
  input  logic [PCLK_W-1:0] slave_pclk,
  input  logic [HT_W-1:0]   master_htotal,
  input  logic [HT_W-1:0]   slave_htotal,
  input  logic [VT_W-1:0]   master_vactive,
  input  logic [DIV_W-1:0]  master_div,
  output logic [HT_W-1:0]   x_calc,
  output logic [VT_W-1:0]   y_calc
);
  localparam logic [63:0] SCALE64 = 64'(SCALE);

  logic [63:0] l_val, x_full, y_full;

  always_comb begin
    l_val  = scaled_lines(SCALE64, 64'(master_pclk), 64'(slave_pclk),
                          64'(master_htotal), 64'(slave_htotal));
    y_full = trigger_line(SCALE64, l_val, 64'(master_vactive));
    x_full = trigger_pixel(SCALE64, l_val, 64'(master_htotal), 64'(master_div));
    x_calc = x_full[HT_W-1:0];
    y_calc = y_full[VT_W-1:0];
  end
endmodule

// File: rtl/aligner_match.sv
module aligner_match #(
  parameter int HT_W = 15,
  parameter int VT_W = 15
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            armed,
  input  logic [HT_W-1:0] hcount,
  input  logic [VT_W-1:0] vcount,
  input  logic [HT_W-1:0] x_pt,
  input  logic [VT_W-1:0] y_pt,
  output logic            hit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit <= 1'b0;
    else        hit <= armed && (hcount == x_pt) && (vcount == y_pt);
  end
endmodule

// File: rtl/aligner_seq.sv
module aligner_seq
  import aligner_pkg::*;
#(
  parameter int HT_W          = 15,
  parameter int VT_W          = 15,
  parameter int POLL_INTERVAL = 10,
  parameter int POLL_LIMIT    = 5000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            slave_running,
  input  logic            match_hit,
  input  logic [HT_W-1:0] x_in,
  input  logic [VT_W-1:0] y_in,
  output logic            slave_en,
  output logic [HT_W-1:0] trig_x,
  output logic [VT_W-1:0] trig_y,
  output logic            trig_armed,
  output logic            lock_master,
  output logic            release_pulse,
  output logic            busy,
  output logic            done,
  output logic            timeout_err
);
  localparam int TICK_W = (POLL_INTERVAL > 1) ? $clog2(POLL_INTERVAL) : 1;
  localparam int POLL_W = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(POLL_INTERVAL - 1);
  localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(POLL_LIMIT - 1);

  align_state_t      state;
  logic [TICK_W-1:0] tick;
  logic [POLL_W-1:0] polls;
  logic              poll_now;
  logic [TICK_W-1:0] tick_nxt;

  assign poll_now      = (tick == '0);
  assign tick_nxt      = (tick == TICK_LAST) ? '0 : tick + 1'b1;
  assign release_pulse = (state == S_WAIT_MATCH) && match_hit;
  assign busy          = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      tick        <= '0;
      polls       <= '0;
      slave_en    <= 1'b0;
      trig_x      <= '0;
      trig_y      <= '0;
      trig_armed  <= 1'b0;
      lock_master <= 1'b0;
      done        <= 1'b0;
      timeout_err <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            slave_en    <= 1'b0;
            timeout_err <= 1'b0;
            state       <= S_CALC;
          end
        end
        S_CALC: begin
          trig_x <= x_in;
          trig_y <= y_in;
          tick   <= '0;
          polls  <= '0;
          state  <= S_STOP_WAIT;
        end
        S_STOP_WAIT: begin
          tick <= tick_nxt;
          if (poll_now) begin
            if (!slave_running) begin
              state <= S_ARM;
            end else if (polls == POLL_LAST) begin
              timeout_err <= 1'b1;
              trig_x      <= '0;
              trig_y      <= '0;
              state       <= S_IDLE;
            end else begin
              polls <= polls + 1'b1;
            end
          end
        end
        S_ARM: begin
          trig_armed  <= 1'b1;
          lock_master <= 1'b1;
          slave_en    <= 1'b1;
          state       <= S_WAIT_MATCH;
        end
        S_WAIT_MATCH: begin
          if (match_hit) begin
            tick  <= '0;
            polls <= '0;
            state <= S_RUN_WAIT;
          end
        end
        S_RUN_WAIT: begin
          tick <= tick_nxt;
          if (poll_now) begin
            if (slave_running) begin
              trig_armed  <= 1'b0;
              lock_master <= 1'b0;
              trig_x      <= '0;
              trig_y      <= '0;
              done        <= 1'b1;
              state       <= S_IDLE;
            end else if (polls == POLL_LAST) begin
              trig_armed  <= 1'b0;
              lock_master <= 1'b0;
              trig_x      <= '0;
              trig_y      <= '0;
              timeout_err <= 1'b1;
              state       <= S_IDLE;
            end else begin
              polls <= polls + 1'b1;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vblank_start_aligner.sv
module vblank_start_aligner #(
  parameter int PCLK_W        = 32,
  parameter int HT_W          = 15,
  parameter int VT_W          = 15,
  parameter int DIV_W         = 8,
  parameter int SCALE         = 10000,
  parameter int POLL_INTERVAL = 10,
  parameter int POLL_LIMIT    = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PCLK_W-1:0] master_pclk,
  input  logic [PCLK_W-1:0] slave_pclk,
  input  logic [HT_W-1:0]   master_htotal,
  input  logic [HT_W-1:0]   slave_htotal,
  input  logic [VT_W-1:0]   master_vactive,
  input  logic [DIV_W-1:0]  master_div,
  input  logic [HT_W-1:0]   master_hcount,
  input  logic [VT_W-1:0]   master_vcount,
  input  logic              slave_running,
  output logic              slave_en,
  output logic [HT_W-1:0]   trig_x,
  output logic [VT_W-1:0]   trig_y,
  output logic              trig_armed,
  output logic              lock_master,
  output logic              release_pulse,
  output logic              busy,
  output logic              done,
  output logic              timeout_err
);
  logic [HT_W-1:0] x_calc;
  logic [VT_W-1:0] y_calc;
  logic            match_hit;

  aligner_calc #(
    .PCLK_W(PCLK_W), .HT_W(HT_W), .VT_W(VT_W), .DIV_W(DIV_W), .SCALE(SCALE)
  ) u_calc (
    .master_pclk   (master_pclk),
    .slave_pclk    (slave_pclk),
    .master_htotal (master_htotal),
    .slave_htotal  (slave_htotal),
    .master_vactive(master_vactive),
    .master_div    (master_div),
    .x_calc        (x_calc),
    .y_calc        (y_calc)
  );

  aligner_match #(.HT_W(HT_W), .VT_W(VT_W)) u_match (
    .clk   (clk),
    .rst_n (rst_n),
    .armed (trig_armed),
    .hcount(master_hcount),
    .vcount(master_vcount),
    .x_pt  (trig_x),
    .y_pt  (trig_y),
    .hit   (match_hit)
  );

  aligner_seq #(
    .HT_W(HT_W), .VT_W(VT_W),
    .POLL_INTERVAL(POLL_INTERVAL), .POLL_LIMIT(POLL_LIMIT)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .slave_running(slave_running),
    .match_hit    (match_hit),
    .x_in         (x_calc),
    .y_in         (y_calc),
    .slave_en     (slave_en),
    .trig_x       (trig_x),
    .trig_y       (trig_y),
    .trig_armed   (trig_armed),
    .lock_master  (lock_master),
    .release_pulse(release_pulse),
    .busy         (busy),
    .done         (done),
    .timeout_err  (timeout_err)
  );
endmodule

// File: rtl/aligner_checker.sv
module aligner_checker #(
  parameter int HT_W = 15,
  parameter int VT_W = 15
) (
  input logic            clk,
  input logic            rst_n,
  input logic            slave_running,
  input logic            slave_en,
  input logic [HT_W-1:0] trig_x,
  input logic [VT_W-1:0] trig_y,
  input logic            trig_armed,
  input logic            lock_master,
  input logic            release_pulse,
  input logic            busy,
  input logic            done
);
  assert_xy_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_armed && $past(trig_armed)) |-> ($stable(trig_x) && $stable(trig_y)));

  assert_en_low_unarmed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !trig_armed) |-> !slave_en);

  assert_stopped_before_arm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_armed) |-> !$past(slave_running, 2));

  assert_arm_together_R6: assert property (@(posedge clk) disable iff (!rst_n)
    release_pulse |-> (trig_armed && lock_master && slave_en));

  assert_single_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    release_pulse |=> !release_pulse);

  assert_disarm_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trig_armed) |-> (trig_x == '0 && trig_y == '0 && !lock_master));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && slave_en));
endmodule

bind vblank_start_aligner aligner_checker #(.HT_W(HT_W), .VT_W(VT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .slave_running(slave_running),
  .slave_en     (slave_en),
  .trig_x       (trig_x),
  .trig_y       (trig_y),
  .trig_armed   (trig_armed),
  .lock_master  (lock_master),
  .release_pulse(release_pulse),
  .busy         (busy),
  .done         (done)
);

// File: tb/vblank_start_aligner_tb.sv
module vblank_start_aligner_tb;
  localparam int PW = 32, HW = 15, VW = 15, DW = 8;
  localparam int INTV = 4, LIM = 6;
  localparam longint unsigned SC = 10000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [PW-1:0] m_pclk = '0, s_pclk = '0;
  logic [HW-1:0] m_ht = 15'd40, s_ht = 15'd40;
  logic [VW-1:0] m_vact = 15'd20;
  logic [DW-1:0] m_div = 8'd1;
  logic [HW-1:0] hc = '0;
  logic [VW-1:0] vc = '0;
  logic [VW-1:0] vtot = 15'd24;
  logic running = 1'b1;
  logic slave_en, armed, lockm, rel, busy, done, terr;
  logic [HW-1:0] tx;
  logic [VW-1:0] ty;

  int nvec = 0, nfail = 0;
  bit finished = 0;
  bit force_hi = 0, force_lo = 0;
  int stop_dly = 0, start_dly = 0;

  always #5 clk = ~clk;

  vblank_start_aligner #(
    .PCLK_W(PW), .HT_W(HW), .VT_W(VW), .DIV_W(DW),
    .POLL_INTERVAL(INTV), .POLL_LIMIT(LIM)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .master_pclk(m_pclk), .slave_pclk(s_pclk),
    .master_htotal(m_ht), .slave_htotal(s_ht),
    .master_vactive(m_vact), .master_div(m_div),
    .master_hcount(hc), .master_vcount(vc),
    .slave_running(running),
    .slave_en(slave_en), .trig_x(tx), .trig_y(ty), .trig_armed(armed),
    .lock_master(lockm), .release_pulse(rel), .busy(busy), .done(done),
    .timeout_err(terr)
  );

  // master raster model
  always @(posedge clk) begin
    if (hc >= m_ht - 1'b1) begin
      hc <= '0;
      vc <= (vc >= vtot - 1'b1) ? '0 : vc + 1'b1;
    end else hc <= hc + 1'b1;
  end

  // slave status model
  always @(posedge clk) begin
    if (!slave_en) begin
      if (stop_dly >= 3) running <= 1'b0; else stop_dly <= stop_dly + 1;
    end else stop_dly <= 0;
    if (rel && slave_en) start_dly <= 1;
    else if (start_dly != 0) begin
      if (start_dly == 5) begin running <= 1'b1; start_dly <= 0; end
      else start_dly <= start_dly + 1;
    end
    if (force_hi) running <= 1'b1;
    if (force_lo) running <= 1'b0;
  end

  function automatic longint unsigned one_if0(longint unsigned v);
    return (v == 0) ? 1 : v;
  endfunction

  // expected point: remainder of the scaled ratio gives the pixel offset
  function automatic void expect_xy(input longint unsigned mp, sp, mh, sh, va, dv,
                                    output longint signed ey, output longint unsigned ex);
    longint unsigned l, whole, frac;
    l     = SC * sh * mp / one_if0(mh) / one_if0(sp);
    whole = l / SC;
    frac  = l % SC;
    ey    = longint'(va) - longint'(whole) - 1;
    ex    = (SC - frac) * one_if0(mh) / one_if0(dv) / SC;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic run_case(input longint unsigned mp, sp, mh, sh, va, dv, input bit poke_busy);
    longint signed ey; longint unsigned ex;
    bit seen_arm = 0; int rels = 0;
    logic [HW-1:0] ph; logic [VW-1:0] pv;
    expect_xy(mp, sp, mh, sh, va, dv, ey, ex);
    @(negedge clk);
    m_pclk = PW'(mp); s_pclk = PW'(sp); m_ht = HW'(mh); s_ht = HW'(sh);
    m_vact = VW'(va); m_div = DW'(dv); vtot = VW'(va + 4);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(slave_en == 1'b0 && terr == 1'b0, "R4/R11 en cleared on start", slave_en, 0);
    @(negedge clk);
    check(ty == VW'(ey), "R2 trig_y", ty, ey);
    check(tx == HW'(ex), "R3 trig_x", tx, ex);
    ph = hc; pv = vc;
    for (int k = 0; k < 30000; k++) begin
      if (busy && !armed && slave_en) check(0, "R4 en high before arm", 1, 0);
      if (armed && !seen_arm) begin
        seen_arm = 1;
        check(lockm && slave_en && rels == 0, "R6 arm together", {lockm, slave_en}, 3);
        if (poke_busy) begin start = 1'b1; @(negedge clk); start = 1'b0; ph = hc; pv = vc; end
      end
      if (rel) begin
        rels++;
        check(ph == HW'(ex) && pv == VW'(ey), "R7 release point", {pv, ph}, {VW'(ey), HW'(ex)});
      end
      if (done) begin
        check(tx == 0 && ty == 0 && !armed && !lockm && slave_en && !busy,
              "R8 disarm", {tx, ty, armed, lockm}, 0);
        check(rels == 1, "R7 single release", rels, 1);
        break;
      end
      ph = hc; pv = vc;
      @(negedge clk);
    end
    check(seen_arm && rels == 1, "R7 run completed", rels, 1);
    if (poke_busy) begin
      repeat (12) @(negedge clk);
      check(!busy && slave_en, "R10 start ignored while busy", busy, 0);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      nvec++; nfail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(!slave_en && !armed && !lockm && !rel && !busy && !done && !terr && tx == 0 && ty == 0,
          "R1 reset state", {slave_en, armed, lockm, busy, terr}, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // directed: whole-line ratio with divider 2, and a zero divider
    run_case(148500, 148500, 40, 40, 20, 2, 1);
    run_case(150000, 149000, 44, 42, 24, 0, 0);

    // random ratios
    for (int n = 0; n < 10; n++) begin
      longint unsigned mp, sp, mh, sh, va, dv, ex; longint signed ey;
      mh = 20 + $urandom_range(0, 39);
      sh = mh + $urandom_range(0, 4) - 2;
      mp = 100000 + $urandom_range(0, 999);
      sp = mp + $urandom_range(0, 200) - 100;
      va = 20 + $urandom_range(0, 19);
      dv = 1 + $urandom_range(0, 1);
      expect_xy(mp, sp, mh, sh, va, dv, ey, ex);
      if (ey < 0 || ey >= longint'(va + 4) || ex >= mh) continue;
      run_case(mp, sp, mh, sh, va, dv, 0);
    end

    // stop-wait timeout
    force_hi = 1;
    @(negedge clk); start = 1'b1;
    begin
      int k = 0;
      for (int c = 0; c < 200; c++) begin
        @(negedge clk); start = 1'b0; k++;
        if (terr) break;
      end
      check(k == 3 + (LIM - 1) * INTV, "R5 stop timeout cycle", k, 3 + (LIM - 1) * INTV);
      check(!busy && !slave_en && !armed, "R5 abort to idle", {busy, slave_en, armed}, 0);
    end
    force_hi = 0;
    repeat (5) @(negedge clk);
    check(terr == 1'b1, "R11 error held", terr, 1);

    // run-wait timeout
    force_lo = 1;
    m_pclk = 100000; s_pclk = 100000; m_ht = 30; s_ht = 30; m_vact = 20; m_div = 2; vtot = 24;
    pulse_start();
    check(terr == 1'b0, "R11 error cleared by start", terr, 0);
    for (int c = 0; c < 5000; c++) begin
      @(negedge clk);
      if (terr) break;
    end
    check(terr && !armed && !lockm && tx == 0 && ty == 0 && !busy,
          "R9 run timeout", {terr, armed, lockm, busy}, 8);
    force_lo = 0;
    repeat (20) @(negedge clk);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule